// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. It runs on a system clock and advances on a receive clock enable pulse (`tick`). That pulse arrives at 16 or 64 times the bit rate, and a static select input picks which. A falling edge on the idle line starts a frame, and a check at mid start bit rejects glitches. Data bits arrive least significant first, and there are 5 to 8 of them. An optional parity bit and one stop bit follow, and the character is then placed in a holding register with a ready flag.

The block keeps sticky parity, framing and overrun flags. These clear only on an error-reset pulse or when the receiver is disabled. A line held low through a whole frame is a break. A break delivers a single all-zero character and raises a break output. Reception then waits until the line returns to mark before it searches for a new start. A framing error that is not a break lets a space that continues into the next bit time act as a new start bit.

Top module: `async_rx_brk`

## Requirements
- R1: After reset, `data_out` is 0 and `ready`, `perr`, `ferr`, `oerr` and `brk_det` are all low.
- R2: A frame has a low start bit, then data bits least significant first, then a stop bit. When the stop bit is sampled, the data is written to `data_out` and `ready` is set. A one-cycle `rd_ack` pulse clears `ready`.
- R3: `char_len` sets the number of data bits: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Unused upper bits of `data_out` read as zero.
- R4: When `par_en` is 1, a parity bit follows the data. `par_even` = 1 selects even parity and 0 selects odd. A mismatch sets `perr`. When `par_en` is 0, no parity bit is expected.
- R5: A low level that is gone at the half-bit sample after the falling edge is discarded. No character is delivered and the search for a start restarts.
- R6: Only the first stop bit is checked, and a low stop sample sets `ferr`. After a framing error that is not a break, a space lasting through the next bit interval is taken as a new start bit.
- R7: A break (the line low for start, data, parity and stop) delivers exactly one character 0x00 with `ferr` set. It does not set `perr`, and it raises `brk_det`. No further character is delivered while the line stays low.
- R8: `brk_det` falls on the first `tick` at which the line is sampled high. The start search resumes from then.
- R9: Writing a character while `ready` is still set (and not acknowledged in the same cycle) sets `oerr`, and the new character replaces the old one.
- R10: `perr`, `ferr` and `oerr` stay set until an `err_clr` pulse. `err_clr` does not change `ready` or `data_out`.
- R11: While `rx_en` is low, `ready`, all error flags and `brk_det` are cleared and any character in progress is dropped.
- R12: `os_sel` = 0 selects 16 ticks per bit and `os_sel` = 1 selects 64. The mid-bit sample is taken half a bit after the detected falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Receive clock enable at the oversampling rate |
| rx_line | input | 1 | Serial input, high = mark |
| rx_en | input | 1 | Receiver enable |
| os_sel | input | 1 | Oversampling factor: 0 = 16, 1 = 64 |
| char_len | input | 2 | Data bit count minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| rd_ack | input | 1 | Holding register read strobe |
| err_clr | input | 1 | Error flag reset pulse |
| data_out | output | 8 | Received character |
| ready | output | 1 | Holding register full |
| perr | output | 1 | Parity error flag |
| ferr | output | 1 | Framing error flag |
| oerr | output | 1 | Overrun error flag |
| brk_det | output | 1 | Break detect output |

## Verification
The bench first sends well-formed frames with several data patterns, lengths and parity settings. These show up bit-order and masking faults. It then sends frames with wrong parity bits and with low stop bits, which separate the parity check from the framing check. It also sends a frame whose stop-bit space runs into a second frame, which shows whether the next start is reused at the right offset. Short glitches, a long held-low break with a late return to mark, back-to-back unread characters, a disable in mid-frame and a 64X-timed frame each isolate one control path: start rejection, single break delivery and mark wait, overrun, abort, and oversampling.

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
  parameter int OS_LO = 16,
  parameter int OS_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_line,
  input  logic       rx_en,
  input  logic       os_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd_ack,
  input  logic       err_clr,
  output logic [7:0] data_out,
  output logic       ready,
  output logic       perr,
  output logic       ferr,
  output logic       oerr,
  output logic       brk_det
);
  localparam int CW = $clog2(OS_HI) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_MARK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          zero_all, pbit, hunt_full, line_q;

  logic [CW-1:0] factor, target;
  logic [2:0]    last_bit;
  logic          due, par_bad, is_brk;

  assign factor   = os_sel ? CW'(OS_HI) : CW'(OS_LO);
  assign target   = (st == S_START && !hunt_full) ? (factor >> 1) : factor;
  assign due      = cnt == target;
  assign last_bit = 3'd4 + {1'b0, char_len};
  assign par_bad  = par_en && (^shreg ^ pbit ^ ~par_even);
  assign is_brk   = zero_all && !rx_line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_q <= 1'b1;
    else if (tick) line_q <= rx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bidx <= '0;
      shreg <= '0;
      zero_all <= 1'b0;
      pbit <= 1'b0;
      hunt_full <= 1'b0;
      data_out <= '0;
      ready <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      oerr <= 1'b0;
      brk_det <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
      ready <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      oerr <= 1'b0;
      brk_det <= 1'b0;
    end else begin
      if (rd_ack) ready <= 1'b0;
      if (err_clr) begin
        perr <= 1'b0;
        ferr <= 1'b0;
        oerr <= 1'b0;
      end
      if (tick) begin
        case (st)
          S_IDLE:
            if (line_q && !rx_line) begin
              st <= S_START;
              cnt <= CW'(1);
              hunt_full <= 1'b0;
            end
          S_START:
            if (due) begin
              if (rx_line) st <= S_IDLE;
              else begin
                st <= S_DATA;
                cnt <= CW'(1);
                bidx <= '0;
                shreg <= '0;
                zero_all <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (due) begin
              shreg[bidx] <= rx_line;
              zero_all <= zero_all & ~rx_line;
              cnt <= CW'(1);
              if (bidx == last_bit) st <= par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (due) begin
              pbit <= rx_line;
              zero_all <= zero_all & ~rx_line;
              cnt <= CW'(1);
              st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (due) begin
              data_out <= shreg;
              ready <= 1'b1;
              if (ready && !rd_ack) oerr <= 1'b1;
              if (!rx_line) ferr <= 1'b1;
              if (is_brk) begin
                brk_det <= 1'b1;
                st <= S_MARK;
              end else begin
                if (par_bad) perr <= 1'b1;
                if (rx_line) st <= S_IDLE;
                else begin
                  st <= S_START;
                  cnt <= CW'(1);
                  hunt_full <= 1'b1;
                end
              end
            end else cnt <= cnt + 1'b1;
          S_MARK:
            if (rx_line) begin
              brk_det <= 1'b0;
              st <= S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_brk_chk.sv
module async_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rx_line,
  input logic       rx_en,
  input logic       rd_ack,
  input logic [7:0] data_out,
  input logic       ready,
  input logic       perr,
  input logic       ferr,
  input logic       oerr,
  input logic       brk_det
);
  // R11
  rx_dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!ready && !perr && !ferr && !oerr && !brk_det));

  // R2
  rdy_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick));

  // R7
  brk_zero_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> (ready && ferr && !perr && data_out == 8'h00));

  // R8
  brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && rx_en && tick && rx_line) |=> !brk_det);

  // R9
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(ready));
endmodule

bind async_rx_brk async_rx_brk_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line), .rx_en(rx_en),
  .rd_ack(rd_ack), .data_out(data_out), .ready(ready), .perr(perr),
  .ferr(ferr), .oerr(oerr), .brk_det(brk_det)
);

// File: tb/async_rx_brk_tb.sv
module async_rx_brk_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_line = 1'b1, rx_en = 1'b0;
  logic os_sel = 1'b0, par_en = 1'b0, par_even = 1'b0, rd_ack = 1'b0, err_clr = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] data_out;
  logic ready, perr, ferr, oerr, brk_det;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  async_rx_brk dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line), .rx_en(rx_en),
    .os_sel(os_sel), .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .rd_ack(rd_ack), .err_clr(err_clr), .data_out(data_out), .ready(ready),
    .perr(perr), .ferr(ferr), .oerr(oerr), .brk_det(brk_det)
  );

  always #5 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
  endtask

  task automatic eclr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  function automatic logic epar(input logic [7:0] d, input int nb, input logic even);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return even ? p : ~p;
  endfunction

  task automatic send(input logic [7:0] d, input int nb, input logic pen, input logic pb,
                      input logic sv, input int tpb);
    hold(1'b0, tpb);
    for (int i = 0; i < nb; i++) hold(d[i], tpb);
    if (pen) hold(pb, tpb);
    hold(sv, tpb);
    if (sv) hold(1'b1, tpb);
  endtask

  task automatic t_reset();
    chk("R1 data", data_out, 0);
    chk("R1 flags", {ready, perr, ferr, oerr, brk_det}, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 8, 0, 0, 1, 16);
    chk("R2 data A5", data_out, 8'hA5);
    chk("R2 ready", ready, 1);
    ack();
    chk("R2 ack clears", ready, 0);
    send(8'h3C, 8, 0, 0, 1, 16);
    chk("R2 data 3C", data_out, 8'h3C);
    chk("R2 no errors", {perr, ferr, oerr}, 0);
    ack();
  endtask

  task automatic t_len();
    char_len = 2'd0;
    send(8'hFF, 5, 0, 0, 1, 16);
    chk("R3 len5", data_out, 8'h1F);
    ack();
    char_len = 2'd1;
    send(8'hFF, 6, 0, 0, 1, 16);
    chk("R3 len6", data_out, 8'h3F);
    ack();
    char_len = 2'd3;
  endtask

  task automatic t_parity();
    char_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
    send(8'h41, 7, 1, epar(8'h41, 7, 1), 1, 16);
    chk("R4 even ok data", data_out, 8'h41);
    chk("R4 even ok perr", perr, 0);
    ack();
    send(8'h41, 7, 1, ~epar(8'h41, 7, 1), 1, 16);
    chk("R4 even bad perr", perr, 1);
    chk("R10 sticky perr ready", ready, 1);
    ack();
    eclr();
    chk("R10 clr perr", perr, 0);
    par_even = 1'b0;
    send(8'h41, 7, 1, epar(8'h41, 7, 0), 1, 16);
    chk("R4 odd ok perr", perr, 0);
    ack();
    par_en = 1'b0; char_len = 2'd3;
  endtask

  task automatic t_false();
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk("R5 glitch no char", ready, 0);
    send(8'h96, 8, 0, 0, 1, 16);
    chk("R5 next char", data_out, 8'h96);
    ack();
  endtask

  task automatic t_frame();
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(8'h5A >> i & 1, 16);
    hold(1'b0, 16);
    chk("R6 fe data", data_out, 8'h5A);
    chk("R6 ferr", ferr, 1);
    ack();
    hold(1'b0, 15);
    for (int i = 0; i < 8; i++) hold(8'h33 >> i & 1, 16);
    hold(1'b1, 32);
    chk("R6 resync data", data_out, 8'h33);
    chk("R6 resync ready", ready, 1);
    chk("R10 ferr sticky", ferr, 1);
    chk("R6 no overrun", oerr, 0);
    ack();
    eclr();
  endtask

  task automatic t_break();
    hold(1'b0, 160);
    hold(1'b0, 48);
    chk("R7 brk data", data_out, 0);
    chk("R7 brk flags", {ready, ferr, perr, brk_det}, 4'b1101);
    ack();
    hold(1'b0, 64);
    chk("R7 single char", ready, 0);
    chk("R7 brk held", brk_det, 1);
    hold(1'b1, 2);
    chk("R8 brk release", brk_det, 0);
    hold(1'b1, 16);
    send(8'h81, 8, 0, 0, 1, 16);
    chk("R8 search resumes", data_out, 8'h81);
    ack();
    eclr();
  endtask

  task automatic t_overrun();
    send(8'h11, 8, 0, 0, 1, 16);
    send(8'h22, 8, 0, 0, 1, 16);
    chk("R9 oerr", oerr, 1);
    chk("R9 replaced", data_out, 8'h22);
    eclr();
    chk("R10 clr oerr", oerr, 0);
    chk("R10 clr keeps ready", ready, 1);
    ack();
  endtask

  task automatic t_disable();
    send(8'h0F, 8, 0, 0, 0, 16);
    hold(1'b1, 32);
    chk("R11 pre ready", {ready, ferr}, 2'b11);
    hold(1'b0, 16); hold(1'b1, 16); hold(1'b0, 16);
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 cleared", {ready, perr, ferr, oerr, brk_det}, 0);
    hold(1'b1, 32);
    rx_en = 1'b1;
    hold(1'b1, 16);
    chk("R11 partial dropped", ready, 0);
    send(8'h7E, 8, 0, 0, 1, 16);
    chk("R11 after enable", data_out, 8'h7E);
    chk("R11 clean flags", ferr, 0);
    ack();
  endtask

  task automatic t_os64();
    os_sel = 1'b1;
    send(8'hC3, 8, 0, 0, 1, 64);
    chk("R12 64x data", data_out, 8'hC3);
    chk("R12 64x ok", {ready, ferr}, 2'b10);
    ack();
    os_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    hold(1'b1, 8);
    t_basic();
    t_len();
    t_parity();
    t_false();
    t_frame();
    t_break();
    t_overrun();
    t_disable();
    t_os64();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule